// File: doc/BRIEF.md
# Parallel ATA PIO Cycle Engine

This block turns a one-word request into one or more programmed-I/O bus cycles on a parallel ATA cable. It sequences the chip selects, the 3-bit device address, the read and write strobes, the output enable of the 16-bit data bus and the capture of read data. The request names a 4-bit device register address, a direction, a write data word, a word count and a choice between two timing sets. One set serves task-file register accesses and the other serves data-port transfers. The phase lengths come from timing fields computed elsewhere as clock counts.

Every word runs through three phases. An address-setup phase drives the bus address and chip select. A strobe phase asserts the read or write strobe; when ready-stretching is enabled, the device can lengthen this phase by pulling its ready line low. A recovery phase negates the strobe while write data stays driven for the hold time. At the end of each word a sticky done flag is set; software clears it by writing a one. A separate control bit drives the device reset pin directly. A start that arrives while the engine is busy, or that names address zero, is dropped.

Top module: `ata_pio_engine`

## Requirements
- R1: While busy, `cs_n` is 2'b10 (select line 0 low) for addresses with bit 3 clear and 2'b01 (select line 1 low) for addresses with bit 3 set, and `da` equals address bits 2:0. While idle, `cs_n` is 2'b11.
- R2: A start with `reg_addr` equal to 0 launches no cycle. Busy stays low and the done flag is unchanged.
- R3: `wr_dir`=1 makes a write: `diow_n` pulses low and `dd_oe` is high with `dd_out` equal to `tx_data`. `wr_dir`=0 makes a read: `dior_n` pulses low and `dd_oe` stays low.
- R4: A word lasts `tim_setup` clocks of setup, then the pulse-width clocks with the strobe low, then `max(recovery, tim_hold)` clocks of recovery. Busy is high for the sum of the three. A setup, pulse or recovery field of 0 counts as 1.
- R5: With `use_data_tim`=0 the pulse and recovery come from `reg_pulse` and `reg_recover`. With `use_data_tim`=1 they come from `dat_pulse` and `dat_recover`. Setup and hold are shared by both sets.
- R6: On writes, `dd_oe` stays high for `tim_hold` clocks after the write strobe negates. If `tim_hold` exceeds the recovery, the recovery is stretched to `tim_hold`.
- R7: With `iordy_en`=1, the strobe stays low past its programmed width until the ready line, seen through a `SYNC_STAGES`-flop synchronizer, is high. With `iordy_en`=0 the ready line has no effect.
- R8: On reads, `rx_data` takes `dd_in` on the clock edge at which `dior_n` negates. `rx_data` changes at no other time.
- R9: `done` is set at the end of every word and then holds. A `clr_done` pulse clears it. When a set and a clear fall on the same edge, the set wins.
- R10: `busy` rises on the edge after an accepted start. A start while busy is ignored, and the address and length in use do not change.
- R11: `xfer_len` words run back to back under one start. A length of 0 runs one word.
- R12: `ata_reset_n` is the inverse of `hw_reset` at all times, whatever the engine is doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Device register address, valid 1 to 15 |
| wr_dir | input | 1 | 1 write to device, 0 read |
| tx_data | input | 16 | Write data word, taken at each word's setup |
| start | input | 1 | Launch request, one clock |
| use_data_tim | input | 1 | 0 register timing set, 1 data timing set |
| xfer_len | input | 8 | Words per start, 0 means 1 |
| tim_setup | input | 8 | Address setup clocks |
| tim_hold | input | 8 | Write data hold clocks |
| reg_pulse | input | 8 | Strobe width, register set |
| reg_recover | input | 8 | Strobe-to-end clocks, register set |
| dat_pulse | input | 8 | Strobe width, data set |
| dat_recover | input | 8 | Strobe-to-end clocks, data set |
| iordy_en | input | 1 | Enable ready stretching |
| iordy | input | 1 | Device ready line |
| clr_done | input | 1 | Write-one-to-clear pulse for the done flag |
| hw_reset | input | 1 | Control bit for the device reset pin |
| dd_in | input | 16 | Data bus from device |
| cs_n | output | 2 | Chip selects, active low |
| da | output | 3 | Device address lines |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| dd_out | output | 16 | Data bus to device |
| dd_oe | output | 1 | Data bus output enable |
| ata_reset_n | output | 1 | Device reset pin, active low |
| rx_data | output | 16 | Last word read |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky word-done flag |

## Verification
The end of a word, which sets the done flag, and a software clear of that flag can land on the same clock edge. To provoke this, the bench counts the busy clocks of a write whose length it knows and raises `clr_done` in the last of those clocks, so that the clear is sampled on the very edge that finishes the word. The flag must read 1 afterwards, and a lone clear issued later must bring it to 0. In the same way, a second start is raised in the middle of a write, and the bench checks that the busy length and the address seen during the strobe match a single undisturbed cycle.

// File: rtl/ata_pio_pkg.sv
// Shared types for the PIO cycle engine.
// Assumes: nothing beyond IEEE 1800-2017.
package ata_pio_pkg;
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SETUP   = 2'd1,
        PH_STROBE  = 2'd2,
        PH_RECOVER = 2'd3
    } pio_phase_e;
endpackage

// File: rtl/ata_pio_decode.sv
// Maps the latched register address onto the two chip selects and the
// device address lines. Outputs are negated while the engine is idle.
// Assumes: the address's top bit selects the control block (select line 1).
module ata_pio_decode #(
    parameter int AW = 4
) (
    input  logic [AW-1:0] addr_q,
    input  logic          active,
    output logic [1:0]    cs_n,
    output logic [AW-2:0] da
);
    localparam int DAW = AW - 1;

    // one select line per generate instance, low when its block is addressed
    for (genvar g = 0; g < 2; g++) begin : g_cs
        assign cs_n[g] = !(active && (addr_q[AW-1] == g[0]));
    end

    // low address bits go straight to the bus while active
    assign da = active ? addr_q[DAW-1:0] : '0;
endmodule

// File: rtl/ata_pio_status.sv
// Sticky done flag with write-one-to-clear; a set on the same edge wins.
// Assumes: clr_done is a single-clock pulse from the register interface.
module ata_pio_status (
    input  logic clk,
    input  logic rst_n,
    input  logic word_end,
    input  logic clr_done,
    output logic done
);
    // hold the flag, clear on request, set at each word end
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else
            done <= (done && !clr_done) || word_end;
    end
endmodule

// File: rtl/ata_pio_seq.sv
// Phase sequencer: setup, strobe (optionally ready-stretched) and recovery
// per word, repeated for the requested word count. Captures read data when
// the strobe negates and tracks the write data hold window.
// Assumes: timing fields are stable for the whole transfer.
module ata_pio_seq
    import ata_pio_pkg::*;
#(
    parameter int TW          = 8,
    parameter int DW          = 16,
    parameter int LW          = 8,
    parameter int AW          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          addr_ok,
    input  logic [AW-1:0] addr,
    input  logic          dir_in,
    input  logic [DW-1:0] wdata,
    input  logic          use_dat,
    input  logic [LW-1:0] len,
    input  logic [TW-1:0] t_setup,
    input  logic [TW-1:0] t_hold,
    input  logic [TW-1:0] reg_pw,
    input  logic [TW-1:0] reg_rec,
    input  logic [TW-1:0] dat_pw,
    input  logic [TW-1:0] dat_rec,
    input  logic          iordy_en,
    input  logic          iordy,
    input  logic [DW-1:0] dd_in,
    output pio_phase_e    phase,
    output logic [AW-1:0] addr_q,
    output logic          dir_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata,
    output logic          hold_on,
    output logic          word_end
);
    logic [TW-1:0] cnt;
    logic [TW-1:0] hold_cnt;
    logic [LW-1:0] words_left;
    logic          dat_q;
    logic          ready_s;
    logic [TW-1:0] pw_sel;
    logic [TW-1:0] rec_load;

    // field value N gives N clocks; zero behaves as one
    function automatic logic [TW-1:0] span(input logic [TW-1:0] v);
        return (v == '0) ? '0 : v - TW'(1);
    endfunction

    // ready line: synchronizer depth chosen by parameter
    if (SYNC_STAGES > 0) begin : g_sync
        logic [SYNC_STAGES-1:0] sr;
        // shift the raw ready line through the synchronizer
        always_ff @(posedge clk) begin
            if (!rst_n)
                sr <= '1;
            else
                sr <= (sr << 1) | SYNC_STAGES'(iordy);
        end
        assign ready_s = sr[SYNC_STAGES-1];
    end else begin : g_direct
        assign ready_s = iordy;
    end

    // timing set selection and recovery length max(recovery, hold)
    always_comb begin
        pw_sel   = dat_q ? dat_pw : reg_pw;
        rec_load = (span(dat_q ? dat_rec : reg_rec) >= span(t_hold))
                   ? span(dat_q ? dat_rec : reg_rec) : span(t_hold);
    end

    assign word_end = (phase == PH_RECOVER) && (cnt == '0);
    assign hold_on  = (phase == PH_RECOVER) && (hold_cnt != '0);

    // phase machine, counters and request latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            cnt        <= '0;
            hold_cnt   <= '0;
            words_left <= '0;
            addr_q     <= '0;
            dir_q      <= 1'b0;
            dat_q      <= 1'b0;
            wdata_q    <= '0;
            rdata      <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start && addr_ok) begin
                        phase      <= PH_SETUP;
                        cnt        <= span(t_setup);
                        addr_q     <= addr;
                        dir_q      <= dir_in;
                        dat_q      <= use_dat;
                        wdata_q    <= wdata;
                        words_left <= (len == '0) ? '0 : len - LW'(1);
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_STROBE;
                        cnt   <= span(pw_sel);
                    end else begin
                        cnt <= cnt - TW'(1);
                    end
                end
                PH_STROBE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - TW'(1);
                    end else if (!iordy_en || ready_s) begin
                        phase    <= PH_RECOVER;
                        cnt      <= rec_load;
                        hold_cnt <= t_hold;
                        if (!dir_q)
                            rdata <= dd_in;
                    end
                end
                PH_RECOVER: begin
                    if (hold_cnt != '0)
                        hold_cnt <= hold_cnt - TW'(1);
                    if (cnt != '0) begin
                        cnt <= cnt - TW'(1);
                    end else if (words_left != '0) begin
                        words_left <= words_left - LW'(1);
                        phase      <= PH_SETUP;
                        cnt        <= span(t_setup);
                        wdata_q    <= wdata;
                    end else begin
                        phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ata_pio_engine.sv
// Top of the PIO cycle engine: accepts a launch request, runs the phase
// sequencer, decodes the bus address and drives strobes and data enable.
// Assumes: iordy is asynchronous (synchronized inside); dd_in is stable
// around the read strobe's negation.
module ata_pio_engine
    import ata_pio_pkg::*;
#(
    parameter int TW          = 8,
    parameter int DW          = 16,
    parameter int LW          = 8,
    parameter int AW          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          wr_dir,
    input  logic [DW-1:0] tx_data,
    input  logic          start,
    input  logic          use_data_tim,
    input  logic [LW-1:0] xfer_len,
    input  logic [TW-1:0] tim_setup,
    input  logic [TW-1:0] tim_hold,
    input  logic [TW-1:0] reg_pulse,
    input  logic [TW-1:0] reg_recover,
    input  logic [TW-1:0] dat_pulse,
    input  logic [TW-1:0] dat_recover,
    input  logic          iordy_en,
    input  logic          iordy,
    input  logic          clr_done,
    input  logic          hw_reset,
    input  logic [DW-1:0] dd_in,
    output logic [1:0]    cs_n,
    output logic [AW-2:0] da,
    output logic          dior_n,
    output logic          diow_n,
    output logic [DW-1:0] dd_out,
    output logic          dd_oe,
    output logic          ata_reset_n,
    output logic [DW-1:0] rx_data,
    output logic          busy,
    output logic          done
);
    pio_phase_e    phase;
    logic [AW-1:0] addr_q;
    logic          dir_q;
    logic          hold_on;
    logic          word_end;
    logic          strobe_on;

    ata_pio_seq #(
        .TW(TW), .DW(DW), .LW(LW), .AW(AW), .SYNC_STAGES(SYNC_STAGES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .addr_ok  (reg_addr != '0),
        .addr     (reg_addr),
        .dir_in   (wr_dir),
        .wdata    (tx_data),
        .use_dat  (use_data_tim),
        .len      (xfer_len),
        .t_setup  (tim_setup),
        .t_hold   (tim_hold),
        .reg_pw   (reg_pulse),
        .reg_rec  (reg_recover),
        .dat_pw   (dat_pulse),
        .dat_rec  (dat_recover),
        .iordy_en (iordy_en),
        .iordy    (iordy),
        .dd_in    (dd_in),
        .phase    (phase),
        .addr_q   (addr_q),
        .dir_q    (dir_q),
        .wdata_q  (dd_out),
        .rdata    (rx_data),
        .hold_on  (hold_on),
        .word_end (word_end)
    );

    ata_pio_decode #(.AW(AW)) u_dec (
        .addr_q (addr_q),
        .active (busy),
        .cs_n   (cs_n),
        .da     (da)
    );

    ata_pio_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_end (word_end),
        .clr_done (clr_done),
        .done     (done)
    );

    // bus-side strobes and data enable from the current phase
    always_comb begin
        busy      = (phase != PH_IDLE);
        strobe_on = (phase == PH_STROBE);
        diow_n    = !(strobe_on && dir_q);
        dior_n    = !(strobe_on && !dir_q);
        dd_oe     = dir_q && ((phase == PH_SETUP) || strobe_on || hold_on);
    end

    // device reset pin follows the control bit directly
    assign ata_reset_n = !hw_reset;
endmodule

// File: rtl/ata_pio_chk.sv
// Protocol checker for the PIO cycle engine, bound to the top module.
// Assumes: observes ports only.
module ata_pio_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          clr_done,
    input logic [1:0]    cs_n,
    input logic [2:0]    da,
    input logic          dior_n,
    input logic          diow_n,
    input logic          dd_oe,
    input logic [DW-1:0] rx_data
);
    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dior_n && !diow_n));
    // R3
    read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dior_n |-> !dd_oe);
    // R1
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n == 2'b11));
    // R1
    cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $onehot(~cs_n));
    // R10
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(da) && $stable(cs_n)));
    // R6
    oe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dd_oe |-> busy);
    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr_done) |=> done);
    // R8
    rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> $rose(dior_n));
endmodule

bind ata_pio_engine ata_pio_chk #(.DW(DW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .clr_done (clr_done),
    .cs_n     (cs_n),
    .da       (da),
    .dior_n   (dior_n),
    .diow_n   (diow_n),
    .dd_oe    (dd_oe),
    .rx_data  (rx_data)
);

// File: tb/test_ata_pio_engine.sv
`timescale 1ns/1ps
module test_ata_pio_engine;
    localparam int SYNC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        wr_dir = 1'b0;
    logic [15:0] tx_data = '0;
    logic        start = 1'b0;
    logic        use_data_tim = 1'b0;
    logic [7:0]  xfer_len = 8'd1;
    logic [7:0]  tim_setup = 8'd2;
    logic [7:0]  tim_hold = 8'd1;
    logic [7:0]  reg_pulse = 8'd5;
    logic [7:0]  reg_recover = 8'd3;
    logic [7:0]  dat_pulse = 8'd3;
    logic [7:0]  dat_recover = 8'd2;
    logic        iordy_en = 1'b0;
    logic        iordy = 1'b1;
    logic        clr_done = 1'b0;
    logic        hw_reset = 1'b0;
    logic [15:0] dd_in = '0;
    logic [1:0]  cs_n;
    logic [2:0]  da;
    logic        dior_n, diow_n, dd_oe, ata_reset_n, busy, done;
    logic [15:0] dd_out, rx_data;

    ata_pio_engine #(.SYNC_STAGES(SYNC)) i_ata_pio_engine (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_dir(wr_dir),
        .tx_data(tx_data), .start(start), .use_data_tim(use_data_tim),
        .xfer_len(xfer_len), .tim_setup(tim_setup), .tim_hold(tim_hold),
        .reg_pulse(reg_pulse), .reg_recover(reg_recover),
        .dat_pulse(dat_pulse), .dat_recover(dat_recover),
        .iordy_en(iordy_en), .iordy(iordy), .clr_done(clr_done),
        .hw_reset(hw_reset), .dd_in(dd_in), .cs_n(cs_n), .da(da),
        .dior_n(dior_n), .diow_n(diow_n), .dd_out(dd_out), .dd_oe(dd_oe),
        .ata_reset_n(ata_reset_n), .rx_data(rx_data), .busy(busy), .done(done)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int busy_n, wr_n, rd_n, hold_n, strobes;
    logic [1:0] cs_seen;
    logic [2:0] da_seen;
    logic data_bad, oe_on_read;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // launch one request and measure it at falling edges until idle
    task automatic run_xfer(input logic [3:0] a, input logic dir, input logic dat,
                            input logic [7:0] len, input int release_at,
                            input int restart_at, input int clr_at);
        logic prev_low = 1'b0;
        logic after = 1'b0;
        logic low;
        busy_n = 0; wr_n = 0; rd_n = 0; hold_n = 0; strobes = 0;
        cs_seen = 2'b11; da_seen = '0; data_bad = 1'b0; oe_on_read = 1'b0;
        reg_addr = a; wr_dir = dir; use_data_tim = dat; xfer_len = len; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) begin
            busy_n++;
            low = !diow_n || !dior_n;
            if (low && !prev_low) strobes++;
            if (!diow_n) wr_n++;
            if (!dior_n) rd_n++;
            if (low) begin
                after = 1'b1;
                cs_seen = cs_n; da_seen = da;
                if (dir && (!dd_oe || dd_out !== tx_data)) data_bad = 1'b1;
            end else if (after && dd_oe) begin
                hold_n++;
            end
            if (!dir && dd_oe) oe_on_read = 1'b1;
            if (release_at > 0 && (wr_n + rd_n) == release_at) iordy = 1'b1;
            start = (restart_at > 0 && busy_n == restart_at);
            if (start) reg_addr = 4'hF;
            clr_done = (clr_at > 0 && busy_n == clr_at);
            prev_low = low;
            @(negedge clk);
        end
        start = 1'b0;
        clr_done = 1'b0;
    endtask

    task automatic clear_done();
        clr_done = 1'b1;
        @(negedge clk);
        clr_done = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 idle cs_n", cs_n, 2'b11);
        check("R9 reset done", done, 0);
        check("R10 reset busy", busy, 0);
        check("R3 reset strobes", {dior_n, diow_n, dd_oe}, 3'b110);
        check("R12 reset pin", ata_reset_n, 1);
    endtask

    task automatic t_write_reg();
        tx_data = 16'hBEEF;
        run_xfer(4'h2, 1'b1, 1'b0, 8'd1, 0, 0, 0);
        check("R4 busy length", busy_n, 10);
        check("R3 write strobe", wr_n, 5);
        check("R3 no read strobe", rd_n, 0);
        check("R1 cs low addr", cs_seen, 2'b10);
        check("R1 da", da_seen, 3'd2);
        check("R3 write data", data_bad, 0);
        check("R6 hold", hold_n, 1);
        check("R9 done set", done, 1);
        clear_done();
        check("R9 w1c", done, 0);
    endtask

    task automatic t_read_dat();
        dd_in = 16'hA5C3;
        run_xfer(4'hE, 1'b0, 1'b1, 8'd1, 0, 0, 0);
        check("R5 data pulse", rd_n, 3);
        check("R5 data busy", busy_n, 7);
        check("R1 cs high addr", cs_seen, 2'b01);
        check("R1 da high", da_seen, 3'd6);
        check("R8 rx capture", rx_data, 16'hA5C3);
        check("R3 read no drive", oe_on_read, 0);
        dd_in = 16'h0000;
        @(negedge clk);
        check("R8 rx holds", rx_data, 16'hA5C3);
        clear_done();
    endtask

    task automatic t_addr_zero();
        run_xfer(4'h0, 1'b1, 1'b0, 8'd1, 0, 0, 0);
        check("R2 no cycle", busy_n, 0);
        @(negedge clk);
        check("R2 still idle", busy, 0);
        check("R2 done untouched", done, 0);
    endtask

    task automatic t_restart();
        tx_data = 16'h1234;
        run_xfer(4'h3, 1'b1, 1'b0, 8'd1, 0, 4, 0);
        check("R10 busy unchanged", busy_n, 10);
        check("R10 addr kept", da_seen, 3'd3);
        @(negedge clk);
        check("R10 no second cycle", busy, 0);
        check("R8 rx untouched by write", rx_data, 16'hA5C3);
        clear_done();
    endtask

    task automatic t_iordy();
        iordy_en = 1'b1; iordy = 1'b0;
        run_xfer(4'h1, 1'b1, 1'b0, 8'd1, 8, 0, 0);
        check("R7 stretched", wr_n, 8 + SYNC);
        iordy_en = 1'b0; iordy = 1'b0;
        run_xfer(4'h1, 1'b1, 1'b0, 8'd1, 0, 0, 0);
        check("R7 disabled ignores", wr_n, 5);
        iordy = 1'b1;
        clear_done();
    endtask

    task automatic t_multi();
        run_xfer(4'h0 + 4'h8, 1'b1, 1'b1, 8'd3, 0, 0, 0);
        check("R11 three words", strobes, 3);
        check("R11 busy total", busy_n, 21);
        run_xfer(4'h8, 1'b1, 1'b1, 8'd0, 0, 0, 0);
        check("R11 zero length", strobes, 1);
        clear_done();
    endtask

    task automatic t_long_hold();
        tim_hold = 8'd6;
        run_xfer(4'h4, 1'b1, 1'b0, 8'd1, 0, 0, 0);
        check("R6 long hold", hold_n, 6);
        check("R6 recovery stretched", busy_n, 13);
        tim_hold = 8'd1;
        tim_setup = 8'd0; reg_pulse = 8'd0;
        run_xfer(4'h4, 1'b1, 1'b0, 8'd1, 0, 0, 0);
        check("R4 zero pulse", wr_n, 1);
        check("R4 zero fields busy", busy_n, 5);
        tim_setup = 8'd2; reg_pulse = 8'd5;
        clear_done();
    endtask

    task automatic t_collide();
        run_xfer(4'h5, 1'b1, 1'b0, 8'd1, 0, 0, 10);
        check("R9 set wins", done, 1);
        clear_done();
        check("R9 later clear", done, 0);
    endtask

    task automatic t_hw_reset();
        hw_reset = 1'b1;
        @(negedge clk);
        check("R12 pin low", ata_reset_n, 0);
        check("R12 engine idle", busy, 0);
        hw_reset = 1'b0;
        @(negedge clk);
        check("R12 pin high", ata_reset_n, 1);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_reg();
        t_read_dat();
        t_addr_zero();
        t_restart();
        t_iordy();
        t_multi();
        t_long_hold();
        t_collide();
        t_hw_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule